// File: doc/BRIEF.md
# Transmit Mailbox Arbitration Selector

This block decides which of eight transmit mailboxes a CAN-style controller sends next. Each mailbox holds a 32-bit arbitration header, a 3-bit local priority and an active bit. Software loads a mailbox through a simple write port and marks it active. When the transmitter reports that it is ready and at least one mailbox is active, the block picks a winner. It latches the winner's index and header onto its outputs and holds them until the transmitter acknowledges completion.

Two run-time inputs choose the ordering. In index mode the lowest active mailbox wins. In header mode the lowest 32-bit header wins. In header mode with local priority enabled, the 3-bit priority is placed above the header and the lowest 35-bit key wins. Every mode breaks a tie in favour of the lower index. On completion the winner's active bit drops and its bit in a write-1-to-clear completion register is set, which raises an interrupt line so software can refill that one mailbox at once.

Top module: `txmb_arbiter`

## Requirements
- R1: After synchronous reset, `tx_valid`, `done_flags` and `irq` are all zero and every mailbox is inactive.
- R2: No selection is issued (`tx_valid` stays low) while `tx_rdy` is low or while no mailbox is active.
- R3: With `order_by_hdr`=0 (index mode), the active mailbox with the lowest index wins, whatever its header or priority and whatever `prio_en` is.
- R4: With `order_by_hdr`=1 and `prio_en`=0, the active mailbox with the lowest 32-bit header wins and the priority field is ignored.
- R5: With `order_by_hdr`=1 and `prio_en`=1, the key is {priority[2:0], header[31:0]} and the lowest key wins, so a smaller priority value beats any header.
- R6: When active mailboxes have equal keys, the one with the lower index wins.
- R7: When `tx_valid` is low, `tx_rdy` is high and a mailbox is active, `tx_valid`, `tx_idx` and `tx_hdr` are registered on the next clock edge. They then hold unchanged until `tx_done` is sampled high, even if a better mailbox is loaded meanwhile.
- R8: `tx_done` sampled high with `tx_valid` high makes `tx_valid` drop on that edge. The same edge clears that mailbox's active bit and sets bit `tx_idx` of `done_flags`, with `irq` high whenever any flag is set. A new selection can follow one cycle later.
- R9: `done_flags` is write-1-to-clear. With `clr_en` high, each bit whose `clr_mask` bit is 1 clears. Other bits are kept, and a completion in the same cycle sets its bit anyway.
- R10: A write to the mailbox that is being selected or is in transmission is ignored. The exception is the cycle in which `tx_done` retires it: there the write lands, and with `wr_act`=1 it requests the mailbox again.
- R11: `tx_done` while `tx_valid` is low has no effect on the flags or on any mailbox.
- R12: A write with `wr_act`=0 to a mailbox that is not locked cancels its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_by_hdr | input | 1 | 0: index order, 1: header order |
| prio_en | input | 1 | In header order, place the local priority above the header |
| wr_en | input | 1 | Mailbox write strobe |
| wr_idx | input | 3 | Mailbox written |
| wr_hdr | input | 32 | Arbitration header to store |
| wr_prio | input | 3 | Local priority to store |
| wr_act | input | 1 | Active bit to store (1 requests transmission) |
| clr_en | input | 1 | Completion flag clear strobe |
| clr_mask | input | 8 | Flags to clear, one bit per mailbox |
| tx_rdy | input | 1 | Transmitter idle and able to accept a selection |
| tx_done | input | 1 | Transmitter finished the selected frame |
| tx_valid | output | 1 | A selection is issued |
| tx_idx | output | 3 | Index of the selected mailbox |
| tx_hdr | output | 32 | Header of the selected mailbox |
| done_flags | output | 8 | Per-mailbox completion flags |
| irq | output | 1 | High while any completion flag is set |

## Verification
The corner cases checked are ties between equal keys, a priority field that must outweigh a smaller header, and index mode with `prio_en` set. A design that broke ties toward the higher index, or compared priorities in index mode, would report the wrong `tx_idx`. A better mailbox loaded during a transfer must not preempt the current one, and a write to the busy mailbox must not change `tx_hdr`. A rewrite landing in the retire cycle must still be requested afterwards, or the refill would be lost. The bench also hits a flag clear in the same cycle as a completion, and a stray `tx_done` while idle, either of which would corrupt `done_flags` in a wrong design.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  localparam int unsigned TXMB_NUM    = 8;
  localparam int unsigned TXMB_HDR_W  = 32;
  localparam int unsigned TXMB_PRIO_W = 3;
endpackage

// File: rtl/txmb_store.sv
module txmb_store #(
  parameter int unsigned NUM_MB = txmb_pkg::TXMB_NUM,
  parameter int unsigned HDR_W  = txmb_pkg::TXMB_HDR_W,
  parameter int unsigned PRIO_W = txmb_pkg::TXMB_PRIO_W,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [HDR_W-1:0]          wr_hdr,
  input  logic [PRIO_W-1:0]         wr_prio,
  input  logic                      wr_act,
  input  logic                      lock_en,
  input  logic [IDX_W-1:0]          lock_idx,
  input  logic                      retire_en,
  input  logic [IDX_W-1:0]          retire_idx,
  output logic [NUM_MB-1:0]         act,
  output logic [NUM_MB*HDR_W-1:0]   hdr_flat,
  output logic [NUM_MB*PRIO_W-1:0]  prio_flat
);
  // One register slot per mailbox: all headers feed the comparator at once.
  for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
    logic [HDR_W-1:0]  hdr_q;
    logic [PRIO_W-1:0] prio_q;
    logic              act_q;
    logic              hit;
    logic              locked;

    assign locked = lock_en && (lock_idx == IDX_W'(g));
    assign hit    = wr_en && (wr_idx == IDX_W'(g)) && !locked;

    always_ff @(posedge clk) begin
      if (rst) begin
        hdr_q  <= '0;
        prio_q <= '0;
        act_q  <= 1'b0;
      end else if (hit) begin
        hdr_q  <= wr_hdr;
        prio_q <= wr_prio;
        act_q  <= wr_act;
      end else if (retire_en && (retire_idx == IDX_W'(g))) begin
        act_q  <= 1'b0;
      end
    end

    assign act[g]                       = act_q;
    assign hdr_flat[g*HDR_W +: HDR_W]   = hdr_q;
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int unsigned NUM_MB = txmb_pkg::TXMB_NUM,
  parameter int unsigned HDR_W  = txmb_pkg::TXMB_HDR_W,
  parameter int unsigned PRIO_W = txmb_pkg::TXMB_PRIO_W,
  localparam int unsigned IDX_W = $clog2(NUM_MB),
  localparam int unsigned KEY_W = PRIO_W + HDR_W
) (
  input  logic [NUM_MB-1:0]         act,
  input  logic [NUM_MB*HDR_W-1:0]   hdr_flat,
  input  logic [NUM_MB*PRIO_W-1:0]  prio_flat,
  input  logic                      order_by_hdr,
  input  logic                      prio_en,
  output logic                      found,
  output logic [IDX_W-1:0]          win
);
  logic [KEY_W-1:0] key [NUM_MB];

  // Index mode gives every mailbox the same key, so only the index decides.
  for (genvar g = 0; g < NUM_MB; g++) begin : g_key
    logic [PRIO_W-1:0] p;
    assign p      = prio_en ? prio_flat[g*PRIO_W +: PRIO_W] : '0;
    assign key[g] = order_by_hdr ? {p, hdr_flat[g*HDR_W +: HDR_W]} : '0;
  end

  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    // Ascending scan with strict compare: on a tie the lower index stays.
    for (int i = 0; i < NUM_MB; i++) begin
      if (act[i] && (!found || (key[i] < best))) begin
        found = 1'b1;
        win   = IDX_W'(i);
        best  = key[i];
      end
    end
  end
endmodule

// File: rtl/txmb_flags.sv
module txmb_flags #(
  parameter int unsigned NUM_MB = txmb_pkg::TXMB_NUM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] set_vec,
  input  logic              clr_en,
  input  logic [NUM_MB-1:0] clr_mask,
  output logic [NUM_MB-1:0] flags,
  output logic              irq
);
  logic [NUM_MB-1:0] flags_nxt;

  // Setting takes precedence over a clear of the same bit.
  assign flags_nxt = (flags & ~(clr_en ? clr_mask : '0)) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |flags_nxt;
    end
  end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
  parameter int unsigned NUM_MB = txmb_pkg::TXMB_NUM,
  parameter int unsigned HDR_W  = txmb_pkg::TXMB_HDR_W,
  parameter int unsigned PRIO_W = txmb_pkg::TXMB_PRIO_W,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               order_by_hdr,
  input  logic               prio_en,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [HDR_W-1:0]   wr_hdr,
  input  logic [PRIO_W-1:0]  wr_prio,
  input  logic               wr_act,
  input  logic               clr_en,
  input  logic [NUM_MB-1:0]  clr_mask,
  input  logic               tx_rdy,
  input  logic               tx_done,
  output logic               tx_valid,
  output logic [IDX_W-1:0]   tx_idx,
  output logic [HDR_W-1:0]   tx_hdr,
  output logic [NUM_MB-1:0]  done_flags,
  output logic               irq
);
  logic [NUM_MB-1:0]        act;
  logic [NUM_MB*HDR_W-1:0]  hdr_flat;
  logic [NUM_MB*PRIO_W-1:0] prio_flat;
  logic                     found;
  logic [IDX_W-1:0]         win;
  logic                     retire;
  logic                     launch;
  logic                     lock_en;
  logic [IDX_W-1:0]         lock_idx;
  logic [NUM_MB-1:0]        set_vec;

  assign retire   = tx_valid && tx_done;
  assign launch   = !tx_valid && tx_rdy && found;
  // Protect the slot being latched or sent; release it in the retire cycle.
  assign lock_en  = (tx_valid && !tx_done) || launch;
  assign lock_idx = tx_valid ? tx_idx : win;
  assign set_vec  = retire ? (NUM_MB'(1) << tx_idx) : '0;

  txmb_store #(.NUM_MB(NUM_MB), .HDR_W(HDR_W), .PRIO_W(PRIO_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_hdr     (wr_hdr),
    .wr_prio    (wr_prio),
    .wr_act     (wr_act),
    .lock_en    (lock_en),
    .lock_idx   (lock_idx),
    .retire_en  (retire),
    .retire_idx (tx_idx),
    .act        (act),
    .hdr_flat   (hdr_flat),
    .prio_flat  (prio_flat)
  );

  txmb_pick #(.NUM_MB(NUM_MB), .HDR_W(HDR_W), .PRIO_W(PRIO_W)) u_pick (
    .act          (act),
    .hdr_flat     (hdr_flat),
    .prio_flat    (prio_flat),
    .order_by_hdr (order_by_hdr),
    .prio_en      (prio_en),
    .found        (found),
    .win          (win)
  );

  txmb_flags #(.NUM_MB(NUM_MB)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .clr_en   (clr_en),
    .clr_mask (clr_mask),
    .flags    (done_flags),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_idx   <= '0;
      tx_hdr   <= '0;
    end else if (retire) begin
      tx_valid <= 1'b0;
    end else if (launch) begin
      tx_valid <= 1'b1;
      tx_idx   <= win;
      tx_hdr   <= hdr_flat[win*HDR_W +: HDR_W];
    end
  end
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk #(
  parameter int unsigned NUM_MB = txmb_pkg::TXMB_NUM,
  parameter int unsigned HDR_W  = txmb_pkg::TXMB_HDR_W,
  localparam int unsigned IDX_W = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_en,
  input logic              tx_done,
  input logic              tx_valid,
  input logic [IDX_W-1:0]  tx_idx,
  input logic [HDR_W-1:0]  tx_hdr,
  input logic [NUM_MB-1:0] done_flags,
  input logic              irq
);
  AST_HOLD_SELECTION: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_done |=> tx_valid && $stable(tx_idx) && $stable(tx_hdr)); // R7

  AST_RETIRE_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_done |=> !tx_valid); // R8

  AST_RETIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_done |=> done_flags[$past(tx_idx)]); // R8

  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq == (done_flags != '0)); // R8

  AST_NO_CLEAR_UNASKED: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> (($past(done_flags) & ~done_flags) == '0)); // R9

  AST_NO_SET_UNRETIRED: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && tx_done) |=> ((done_flags & ~$past(done_flags)) == '0)); // R11
endmodule

bind txmb_arbiter txmb_arbiter_chk #(.NUM_MB(NUM_MB), .HDR_W(HDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_en     (clr_en),
  .tx_done    (tx_done),
  .tx_valid   (tx_valid),
  .tx_idx     (tx_idx),
  .tx_hdr     (tx_hdr),
  .done_flags (done_flags),
  .irq        (irq)
);

// File: tb/txmb_arbiter_test.sv
`timescale 1ns/1ps
module txmb_arbiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        order_by_hdr = 1'b0;
  logic        prio_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_hdr = '0;
  logic [2:0]  wr_prio = '0;
  logic        wr_act = 1'b0;
  logic        clr_en = 1'b0;
  logic [7:0]  clr_mask = '0;
  logic        tx_rdy = 1'b0;
  logic        tx_done = 1'b0;
  logic        tx_valid;
  logic [2:0]  tx_idx;
  logic [31:0] tx_hdr;
  logic [7:0]  done_flags;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  txmb_arbiter uut (
    .clk(clk), .rst(rst), .order_by_hdr(order_by_hdr), .prio_en(prio_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hdr(wr_hdr), .wr_prio(wr_prio),
    .wr_act(wr_act), .clr_en(clr_en), .clr_mask(clr_mask), .tx_rdy(tx_rdy),
    .tx_done(tx_done), .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_hdr(tx_hdr),
    .done_flags(done_flags), .irq(irq)
  );

  // Fixed mailbox contents for the table: header order 4=7 < 6 < 1=2 < 3 < 5 < 0.
  function automatic logic [31:0] hdr_of(int i);
    case (i)
      0: return 32'h0A00_0500;
      1: return 32'h0300_0300;
      2: return 32'h0300_0300;
      3: return 32'h0700_0007;
      4: return 32'h0100_0001;
      5: return 32'h0900_0000;
      6: return 32'h0200_0000;
      default: return 32'h0100_0001;
    endcase
  endfunction

  function automatic logic [2:0] prio_of(int i);
    case (i)
      0: return 3'd3;
      1: return 3'd2;
      2: return 3'd2;
      3: return 3'd0;
      4: return 3'd5;
      5: return 3'd1;
      6: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // {order_by_hdr, prio_en, active mask, expected winner}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 1'b0, 8'hFF, 3'd0},  // R3
    {1'b0, 1'b0, 8'hF0, 3'd4},  // R3
    {1'b0, 1'b0, 8'h28, 3'd3},  // R3
    {1'b1, 1'b0, 8'hFF, 3'd4},  // R4, R6 tie 4/7
    {1'b1, 1'b0, 8'h6E, 3'd6},  // R4
    {1'b1, 1'b0, 8'h06, 3'd1},  // R6 tie 1/2
    {1'b1, 1'b1, 8'hFF, 3'd3},  // R5
    {1'b1, 1'b1, 8'hD7, 3'd1},  // R5, R6
    {1'b1, 1'b1, 8'h90, 3'd4},  // R6
    {1'b1, 1'b1, 8'hC0, 3'd6},  // R5 priority beats header
    {1'b1, 1'b0, 8'hC0, 3'd7},  // R4 priority ignored
    {1'b0, 1'b1, 8'h50, 3'd4}   // R3 priority ignored in index mode
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tx_rdy = 1'b0;
    tx_done = 1'b0;
    wr_en = 1'b0;
    clr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(int i, logic [31:0] h, logic [2:0] p, logic a);
    wr_en = 1'b1;
    wr_idx = 3'(i);
    wr_hdr = h;
    wr_prio = p;
    wr_act = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  initial begin
    do_reset();
    chk("R1 valid", 32'(tx_valid), 0);
    chk("R1 flags", 32'(done_flags), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2: ready but nothing active, then active but not ready
    tx_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no active", 32'(tx_valid), 0);
    tx_rdy = 1'b0;
    wr(2, 32'h10, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R2 not ready", 32'(tx_valid), 0);

    // Table: R3 R4 R5 R6 R7
    for (int v = 0; v < 12; v++) begin
      logic [7:0] m;
      logic [2:0] e;
      do_reset();
      m = VEC[v][10:3];
      e = VEC[v][2:0];
      for (int i = 0; i < 8; i++) wr(i, hdr_of(i), prio_of(i), m[i]);
      order_by_hdr = VEC[v][12];
      prio_en = VEC[v][11];
      tx_rdy = 1'b1;
      @(negedge clk);
      chk($sformatf("R7 valid vec%0d", v), 32'(tx_valid), 1);
      chk($sformatf("R3/R4/R5/R6 idx vec%0d", v), 32'(tx_idx), 32'(e));
      chk($sformatf("R7 hdr vec%0d", v), tx_hdr, hdr_of(int'(e)));
    end

    // R8 and R9: completion, reselection, clear
    do_reset();
    order_by_hdr = 1'b1;
    prio_en = 1'b0;
    wr(0, 32'h500, 3'd0, 1'b1);
    wr(4, 32'h100, 3'd0, 1'b1);
    tx_rdy = 1'b1;
    @(negedge clk);
    chk("R4 first pick", 32'(tx_idx), 4);
    pulse_done();
    chk("R8 valid drops", 32'(tx_valid), 0);
    chk("R8 flag set", 32'(done_flags), 32'h10);
    chk("R8 irq", 32'(irq), 1);
    @(negedge clk);
    chk("R8 reselect valid", 32'(tx_valid), 1);
    chk("R8 reselect idx", 32'(tx_idx), 0);
    clr_en = 1'b1;
    clr_mask = 8'h11;
    pulse_done();
    clr_en = 1'b0;
    chk("R9 set wins over clear", 32'(done_flags), 32'h01);
    clr_en = 1'b1;
    clr_mask = 8'h01;
    @(negedge clk);
    clr_en = 1'b0;
    chk("R9 cleared", 32'(done_flags), 0);
    chk("R9 irq low", 32'(irq), 0);
    chk("R8 retired inactive", 32'(tx_valid), 0);

    // R11: stray completion while idle
    pulse_done();
    @(negedge clk);
    chk("R11 flags", 32'(done_flags), 0);
    chk("R11 valid", 32'(tx_valid), 0);

    // R7 and R10: no preemption, locked slot, retire-cycle rewrite
    wr(5, 32'h900, 3'd0, 1'b1);
    @(negedge clk);
    chk("R7 pick 5", 32'(tx_idx), 5);
    wr(1, 32'h050, 3'd0, 1'b1);
    wr(5, 32'h001, 3'd0, 1'b0);
    @(negedge clk);
    chk("R7 no preempt", 32'(tx_idx), 5);
    chk("R10 locked hdr", tx_hdr, 32'h900);
    tx_done = 1'b1;
    wr_en = 1'b1;
    wr_idx = 3'd5;
    wr_hdr = 32'h002;
    wr_prio = 3'd0;
    wr_act = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    wr_en = 1'b0;
    chk("R8 flag 5", 32'(done_flags), 32'h20);
    @(negedge clk);
    chk("R10 rewrite requested idx", 32'(tx_idx), 5);
    chk("R10 rewrite hdr", tx_hdr, 32'h002);

    // R12: cancel mailbox 1 while 5 is in flight
    wr(1, 32'h050, 3'd0, 1'b0);
    pulse_done();
    @(negedge clk);
    chk("R12 cancelled", 32'(tx_valid), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule